// File: doc/BRIEF.md
# Vector Bit-Manipulation Execution Unit

This unit executes one element-wise bit-manipulation instruction over a vector, one element per clock. A command supplies an operation code, an element width, a masking flag, the mask bits, a choice between a per-element second operand and a broadcast scalar, and a first and end element index. Once accepted, the unit walks the indices from the first index up to one below the end index. For each index it presents a read index to the register file, combines the two returned operands and issues a write request for the destination element. Lanes that are masked off consume their cycle but produce no write.

The five operations are:
- AND with the complement of the second operand.
- Reversal of bit order inside every byte of the element.
- Reversal of byte order within the element width.
- Left rotation by an amount reduced modulo the element width.
- Right rotation by an amount reduced modulo the element width.

When the walk ends, a single-cycle `done` pulse tells the surrounding core to mark vector state modified and to clear its restart index.

The control is a three-state machine:
- `ST_IDLE` waits for a command and is the only state with `ready` high.
- `ST_RUN` processes one index per cycle.
- `ST_FIN` raises `done` for one cycle, then always returns to `ST_IDLE`.

Its transitions are:
- IDLE→RUN on an accepted command whose first index is below the end index.
- IDLE→FIN on an accepted command with an empty range.
- RUN→RUN while indices remain.
- RUN→FIN after the last index.
- FIN→IDLE unconditionally.

Top module: `vbm_unit`

## Requirements
- R1: After a command is accepted on a rising edge with `go` high and `ready` high, index `vstart+k` is driven on `rd_idx` in cycle k+1. Its write request, if any, appears on `wr_en`/`wr_idx`/`wr_data` one cycle later. Indices are visited in strictly ascending order, one per cycle, up to `vl-1`.
- R2: With `vm`=1, an index whose `v0_mask` bit (bit position = element index) is 0 produces no write (`wr_en` stays 0 in its slot). With `vm`=0, every index in the range is written. `v0_mask` is captured when the command is accepted.
- R3: Opcode 0 (and-not) writes `a & ~b`. Here `a` is `vs2_data`, and `b` is `vs1_data` when `src_scalar`=0 or the captured `scalar` when `src_scalar`=1.
- R4: Opcode 1 (bit-reverse in bytes) moves bit k of each byte to bit 7-k of the same byte; no byte changes position.
- R5: Opcode 2 (byte reverse) maps byte j of the element to byte n-1-j, where n is the element width in bytes; bytes above the element width are not used.
- R6: Opcode 3 (rotate left) rotates `a` left by `b` modulo the element width in bits. An amount of 0 or any multiple of the width returns `a` unchanged.
- R7: Opcode 4 (rotate right) rotates `a` right by `b` modulo the element width in bits. The same modulo rule holds.
- R8: Element width code `ew` 0,1,2,3 selects 8,16,32,64 bits. Every written result has all bits at and above the element width equal to zero, whatever the operands hold there.
- R9: `done` is high for exactly one cycle, in the cycle holding the write slot of the last index. When `vstart` >= `vl`, no write occurs and `done` rises in the cycle right after acceptance.
- R10: `ready` is high only when idle. A `go` raised while not ready is ignored, and the running command keeps its captured parameters.
- R11: During and right after reset, `ready`=1, `done`=0 and `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Command strobe, taken when ready |
| ready | output | 1 | Unit idle, command can be accepted |
| op | input | 3 | Operation code |
| ew | input | 2 | Element width code |
| vm | input | 1 | Masking enable |
| src_scalar | input | 1 | Second operand from scalar (1) or vector (0) |
| scalar | input | ELEN | Scalar second operand |
| v0_mask | input | MAXVL | Per-element mask bits |
| vstart | input | IDXW | First element index |
| vl | input | IDXW | End index (exclusive) |
| rd_idx | output | IDXW | Element index being read |
| vs2_data | input | ELEN | First operand element at rd_idx |
| vs1_data | input | ELEN | Second vector operand element at rd_idx |
| wr_en | output | 1 | Destination write request |
| wr_idx | output | IDXW | Destination element index |
| wr_data | output | ELEN | Result element |
| done | output | 1 | End of command; mark state modified, clear start index |

## Verification
The hardest condition to reach from the ports is a `go` raised in mid-walk with different parameters. A fault there shows up only as altered results for the elements still to come. The stimulus raises such a strobe during a masked run and lets the reference model, which ignores it, expose any disturbance. Rotations by exact multiples of the element width come from a second vector operand filled with multiples of four, so every width meets the zero-amount case. Other runs mask off the final index so that `done` falls on a silent slot, and use empty and inverted ranges.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

    typedef enum logic [2:0] {
        OP_ANDN  = 3'd0,
        OP_BREVB = 3'd1,
        OP_BSWAP = 3'd2,
        OP_ROTL  = 3'd3,
        OP_ROTR  = 3'd4
    } vbm_op_e;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } vbm_ew_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vbm_state_e;

    function automatic logic [7:0] ew_bits(input logic [1:0] ew);
        return 8'd8 << ew;
    endfunction

endpackage

// File: rtl/vbm_ctrl.sv
module vbm_ctrl
    import vbm_pkg::*;
#(
    parameter int ELEN  = 64,
    parameter int MAXVL = 32,
    parameter int IDXW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [2:0]       op_i,
    input  logic [1:0]       ew_i,
    input  logic             vm_i,
    input  logic             src_scalar_i,
    input  logic [ELEN-1:0]  scalar_i,
    input  logic [MAXVL-1:0] v0_i,
    input  logic [IDXW-1:0]  vstart_i,
    input  logic [IDXW-1:0]  vl_i,
    output logic             ready,
    output logic             done,
    output logic             fire,
    output logic [IDXW-1:0]  idx,
    output logic [2:0]       op_q,
    output logic [1:0]       ew_q,
    output logic             vm_q,
    output logic             src_scalar_q,
    output logic [ELEN-1:0]  scalar_q,
    output logic [MAXVL-1:0] v0_q,
    output logic [IDXW-1:0]  vstart_q,
    output logic [IDXW-1:0]  vl_q
);
    localparam int LW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    vbm_state_e state, nxt;
    logic [IDXW-1:0] vl_eff;
    logic            last;
    logic            accept;

    assign vl_eff = (vl_i > IDXW'(MAXVL)) ? IDXW'(MAXVL) : vl_i;
    assign accept = (state == ST_IDLE) && go;
    assign last   = ((idx + IDXW'(1)) >= vl_q);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = (vstart_i < vl_eff) ? ST_RUN : ST_FIN;
            ST_RUN:  if (last) nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // index and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx          <= '0;
            op_q         <= '0;
            ew_q         <= '0;
            vm_q         <= 1'b0;
            src_scalar_q <= 1'b0;
            scalar_q     <= '0;
            v0_q         <= '0;
            vstart_q     <= '0;
            vl_q         <= '0;
        end else if (accept) begin
            idx          <= vstart_i;
            op_q         <= op_i;
            ew_q         <= ew_i;
            vm_q         <= vm_i;
            src_scalar_q <= src_scalar_i;
            scalar_q     <= scalar_i;
            v0_q         <= v0_i;
            vstart_q     <= vstart_i;
            vl_q         <= vl_eff;
        end else if (state == ST_RUN) begin
            idx <= idx + IDXW'(1);
        end
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        done  = 1'b0;
        fire  = 1'b0;
        unique case (state)
            ST_IDLE: ready = 1'b1;
            ST_RUN:  fire  = !vm_q || v0_q[idx[LW-1:0]];
            ST_FIN:  done  = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN)) |-> ($stable(op_q) && $stable(vl_q) && $stable(scalar_q))); // R10

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN)) |-> (idx == $past(idx) + IDXW'(1))); // R1

endmodule

// File: rtl/vbm_alu.sv
module vbm_alu
    import vbm_pkg::*;
#(
    parameter int ELEN = 64
) (
    input  logic [2:0]      op,
    input  logic [1:0]      ew,
    input  logic [ELEN-1:0] a,
    input  logic [ELEN-1:0] b,
    output logic [ELEN-1:0] res
);
    localparam int NB = ELEN / 8;

    logic [7:0]      w;
    logic [7:0]      sh;
    logic [7:0]      nbytes;
    logic [ELEN-1:0] mask;
    logic [ELEN-1:0] am;
    logic [ELEN-1:0] brev;
    logic [ELEN-1:0] bswap;
    logic [ELEN-1:0] rotl;
    logic [ELEN-1:0] rotr;

    assign w      = ew_bits(ew);
    assign nbytes = w >> 3;
    assign mask   = (ELEN'(1) << w) - ELEN'(1);
    assign am     = a & mask;
    assign sh     = b[7:0] & (w - 8'd1);

    // bit order flipped inside each byte lane
    for (genvar j = 0; j < NB; j++) begin : g_lane
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign brev[8*j + k] = am[8*j + 7 - k];
        end
    end

    always_comb begin
        bswap = '0;
        for (int j = 0; j < NB; j++) begin
            if (j < int'(nbytes)) begin
                bswap[8*j +: 8] = am[8*(int'(nbytes) - 1 - j) +: 8];
            end
        end
    end

    assign rotl = ((am << sh) | (am >> (w - sh))) & mask;
    assign rotr = ((am >> sh) | (am << (w - sh))) & mask;

    always_comb begin
        case (op)
            OP_ANDN:  res = am & ~b;
            OP_BREVB: res = brev;
            OP_BSWAP: res = bswap;
            OP_ROTL:  res = rotl;
            OP_ROTR:  res = rotr;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/vbm_wrstage.sv
module vbm_wrstage
    import vbm_pkg::*;
#(
    parameter int ELEN = 64,
    parameter int IDXW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [IDXW-1:0] idx,
    input  logic [ELEN-1:0] res,
    input  logic [1:0]      ew,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [ELEN-1:0] wr_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) begin
                wr_idx  <= idx;
                wr_data <= res;
            end
        end
    end

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~((ELEN'(1) << ew_bits(ew)) - ELEN'(1))) == '0)); // R8

endmodule

// File: rtl/vbm_unit.sv
module vbm_unit
    import vbm_pkg::*;
#(
    parameter int ELEN  = 64,
    parameter int MAXVL = 32,
    localparam int IDXW = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             ready,
    input  logic [2:0]       op,
    input  logic [1:0]       ew,
    input  logic             vm,
    input  logic             src_scalar,
    input  logic [ELEN-1:0]  scalar,
    input  logic [MAXVL-1:0] v0_mask,
    input  logic [IDXW-1:0]  vstart,
    input  logic [IDXW-1:0]  vl,
    output logic [IDXW-1:0]  rd_idx,
    input  logic [ELEN-1:0]  vs2_data,
    input  logic [ELEN-1:0]  vs1_data,
    output logic             wr_en,
    output logic [IDXW-1:0]  wr_idx,
    output logic [ELEN-1:0]  wr_data,
    output logic             done
);
    localparam int LW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    logic             fire;
    logic [IDXW-1:0]  idx;
    logic [2:0]       op_q;
    logic [1:0]       ew_q;
    logic             vm_q;
    logic             src_scalar_q;
    logic [ELEN-1:0]  scalar_q;
    logic [MAXVL-1:0] v0_q;
    logic [IDXW-1:0]  vstart_q;
    logic [IDXW-1:0]  vl_q;
    logic [ELEN-1:0]  opnd_b;
    logic [ELEN-1:0]  res;

    vbm_ctrl #(.ELEN(ELEN), .MAXVL(MAXVL), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go),
        .op_i(op), .ew_i(ew), .vm_i(vm), .src_scalar_i(src_scalar),
        .scalar_i(scalar), .v0_i(v0_mask), .vstart_i(vstart), .vl_i(vl),
        .ready(ready), .done(done), .fire(fire), .idx(idx),
        .op_q(op_q), .ew_q(ew_q), .vm_q(vm_q), .src_scalar_q(src_scalar_q),
        .scalar_q(scalar_q), .v0_q(v0_q), .vstart_q(vstart_q), .vl_q(vl_q)
    );

    assign rd_idx = idx;
    assign opnd_b = src_scalar_q ? scalar_q : vs1_data;

    vbm_alu #(.ELEN(ELEN)) u_alu (
        .op(op_q), .ew(ew_q), .a(vs2_data), .b(opnd_b), .res(res)
    );

    vbm_wrstage #(.ELEN(ELEN), .IDXW(IDXW)) u_wr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .idx(idx), .res(res),
        .ew(ew_q), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx >= vstart_q && wr_idx < vl_q)); // R1

    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx))); // R1

    AST_MASK_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vm_q) |-> v0_q[wr_idx[LW-1:0]]); // R2

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready); // R10

endmodule

// File: tb/sim_vbm_unit.sv
`timescale 1ns/1ps
module sim_vbm_unit;
    localparam int ELEN  = 64;
    localparam int MAXVL = 32;
    localparam int IDXW  = $clog2(MAXVL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             go = 1'b0;
    logic             ready;
    logic [2:0]       op = '0;
    logic [1:0]       ew = '0;
    logic             vm = 1'b0;
    logic             src_scalar = 1'b0;
    logic [ELEN-1:0]  scalar = '0;
    logic [MAXVL-1:0] v0_mask = '0;
    logic [IDXW-1:0]  vstart = '0;
    logic [IDXW-1:0]  vl = '0;
    logic [IDXW-1:0]  rd_idx;
    logic [ELEN-1:0]  vs2_data;
    logic [ELEN-1:0]  vs1_data;
    logic             wr_en;
    logic [IDXW-1:0]  wr_idx;
    logic [ELEN-1:0]  wr_data;
    logic             done;

    logic [63:0] vs2_mem [MAXVL];
    logic [63:0] vs1_mem [MAXVL];

    assign vs2_data = (int'(rd_idx) < MAXVL) ? vs2_mem[rd_idx[4:0]] : 64'h0;
    assign vs1_data = (int'(rd_idx) < MAXVL) ? vs1_mem[rd_idx[4:0]] : 64'h0;

    vbm_unit #(.ELEN(ELEN), .MAXVL(MAXVL)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .ready(ready), .op(op), .ew(ew),
        .vm(vm), .src_scalar(src_scalar), .scalar(scalar), .v0_mask(v0_mask),
        .vstart(vstart), .vl(vl), .rd_idx(rd_idx), .vs2_data(vs2_data),
        .vs1_data(vs1_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done)
    );

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;
    string op_tag [5] = '{"R3", "R4", "R5", "R6", "R7"};

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] ref_op(input int o, input int e,
                                           input logic [63:0] a, input logic [63:0] b);
        int w;
        int nb;
        int sh;
        logic [63:0] r;
        w  = 8 << e;
        nb = w / 8;
        sh = int'(b % 64'(w));
        r  = '0;
        for (int j = 0; j < w; j++) begin
            case (o)
                0: r[j] = a[j] & ~b[j];
                1: r[j] = a[(j / 8) * 8 + 7 - (j % 8)];
                2: r[j] = a[(nb - 1 - j / 8) * 8 + (j % 8)];
                3: r[(j + sh) % w] = a[j];
                4: r[j] = a[(j + sh) % w];
                default: r[j] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // behavioural reference: 0 idle, 1 walking, 2 finishing
    int          m_state = 0;
    int          m_idx = 0;
    int          m_vl = 0;
    int          m_op = 0;
    int          m_ew = 0;
    bit          m_vm = 0;
    bit          m_srcs = 0;
    logic [63:0] m_scalar = '0;
    logic [31:0] m_v0 = '0;
    bit          m_wr = 0;
    int          m_wr_idx = 0;
    logic [63:0] m_wr_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            m_wr = 0;
        end else begin
            m_wr = 0;
            if (m_state == 0) begin
                if (go) begin
                    m_op = int'(op); m_ew = int'(ew); m_vm = vm; m_srcs = src_scalar;
                    m_scalar = scalar; m_v0 = v0_mask; m_vl = int'(vl);
                    m_idx = int'(vstart);
                    m_state = (m_idx < m_vl) ? 1 : 2;
                end
            end else if (m_state == 1) begin
                if (!m_vm || m_v0[m_idx]) begin
                    m_wr = 1;
                    m_wr_idx = m_idx;
                    m_wr_data = ref_op(m_op, m_ew, vs2_mem[m_idx],
                                       m_srcs ? m_scalar : vs1_mem[m_idx]);
                end
                m_idx++;
                if (m_idx >= m_vl) m_state = 2;
            end else begin
                m_state = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            check(ready == (m_state == 0), "R10", 64'(ready), 64'(m_state == 0));
            check(done == (m_state == 2), "R9", 64'(done), 64'(m_state == 2));
            check(wr_en == m_wr, "R2", 64'(wr_en), 64'(m_wr));
            if (wr_en && m_wr) begin
                check(int'(wr_idx) == m_wr_idx, "R1", 64'(wr_idx), 64'(m_wr_idx));
                check(wr_data == m_wr_data, op_tag[m_op], wr_data, m_wr_data);
                check((wr_data >> (8 << m_ew)) == 0 || m_ew == 3, "R8", wr_data, m_wr_data);
            end
        end
    end

    task automatic fill(input bit multiples);
        for (int i = 0; i < MAXVL; i++) begin
            vs2_mem[i] = {$urandom, $urandom};
            vs1_mem[i] = multiples ? 64'(i * 4) : {$urandom, $urandom};
        end
    endtask

    task automatic run(input int o, input int e, input bit m, input bit s,
                       input logic [63:0] sc, input logic [31:0] v0,
                       input int vs, input int l, input bit poke);
        @(posedge clk); #1;
        op = 3'(o); ew = 2'(e); vm = m; src_scalar = s; scalar = sc;
        v0_mask = v0; vstart = IDXW'(vs); vl = IDXW'(l); go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
        if (poke) begin
            // R10: strobe with other parameters while busy
            op = 3'((o + 1) % 5); ew = 2'(e + 1); vm = ~m; src_scalar = ~s;
            scalar = ~sc; v0_mask = ~v0; vstart = '0; vl = IDXW'(MAXVL); go = 1'b1;
            @(posedge clk); #1;
            go = 1'b0;
        end
        while (!ready) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        fill(1'b0);
        repeat (3) begin
            @(negedge clk);
            check(ready == 1'b1 && done == 1'b0 && wr_en == 1'b0, "R11",
                  {61'd0, ready, done, wr_en}, 64'd4);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0 && wr_en == 1'b0, "R11",
              {61'd0, ready, done, wr_en}, 64'd4);
        chk_on = 1'b1;

        // R3 full-length unmasked vector and-not
        run(0, 3, 1'b0, 1'b0, 64'h0, 32'h0, 0, 32, 1'b0);
        // every operation and width, masked, mixed sources (R2..R8)
        for (int o = 0; o < 5; o++) begin
            for (int e = 0; e < 4; e++) begin
                fill(1'b0);
                run(o, e, 1'b1, 1'((o + e) % 2), {$urandom, $urandom}, $urandom,
                    o, 20 + e, 1'b0);
            end
        end
        // rotate amounts from vector: multiples of width included (R6, R7)
        fill(1'b1);
        for (int e = 0; e < 4; e++) begin
            run(3, e, 1'b0, 1'b0, 64'h0, 32'h0, 0, 32, 1'b0);
            run(4, e, 1'b0, 1'b0, 64'h0, 32'h0, 0, 32, 1'b0);
            run(3, e, 1'b0, 1'b1, 64'(8 << e), 32'h0, 0, 6, 1'b0);
            run(4, e, 1'b0, 1'b1, 64'(3 * (8 << e) + 5), 32'h0, 0, 6, 1'b0);
            run(4, e, 1'b0, 1'b1, 64'h0, 32'h0, 0, 6, 1'b0);
        end
        // R9 empty and inverted ranges
        run(1, 2, 1'b0, 1'b0, 64'h0, 32'h0, 5, 5, 1'b0);
        run(2, 1, 1'b0, 1'b0, 64'h0, 32'h0, 9, 3, 1'b0);
        run(0, 0, 1'b0, 1'b0, 64'h0, 32'h0, 0, 0, 1'b0);
        // R9 last index masked off, R1 single element
        fill(1'b0);
        run(2, 3, 1'b1, 1'b0, 64'h0, 32'h0000_007F, 2, 8, 1'b0);
        run(3, 2, 1'b0, 1'b1, 64'd7, 32'h0, 31, 32, 1'b0);
        // R10 strobe while busy
        run(4, 1, 1'b1, 1'b1, 64'd5, 32'hA5A5_5A5A, 1, 12, 1'b1);
        run(0, 0, 1'b0, 1'b0, 64'h0, 32'h0, 3, 4, 1'b1);

        chk_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule